// File: doc/BRIEF.md
# Write-Back Block Cache with Early Word Return

This block sits between a processor request port and a slower word-wide memory port. The processor issues ordinary reads and writes using memory word addresses and needs no knowledge that a cache is present: every read returns the current memory contents of that address, whether it comes from the cache or from memory. The cache is direct-mapped. Each line holds one block of consecutive words together with a valid flag and a modified flag.

When a read misses, the block that holds the address is fetched from memory one word per handshake, starting at the block's first word. The requested word is handed to the processor on the beat that delivers it, while the rest of the block is still arriving. Writes change only the cached copy and mark the line as modified. When a line has to make room for another block, a modified line is first copied back to memory. An unmodified line is simply overwritten. A write miss first brings the block in and then merges the written word into it. While a copy-back or refill is running, any new processor request waits until the controller is idle again.

Top module: `wbcache_lt`

## Requirements
- R1: After reset no line is valid and both `cpu_rdy` and `mem_req` are low, so the first access to any address causes a block fetch from memory.
- R2: A read whose address is held in the cache returns the cached word with `cpu_rdy` high on the first clock edge after the request is presented, and causes no memory traffic.
- R3: On a read miss the whole block of `WORDS` words is read from memory, one word per `mem_req`/`mem_ack` handshake, at word offsets 0, 1, ..., `WORDS`-1 in that order. `mem_addr`, `mem_we` and `mem_wdata` stay stable while `mem_req` waits for `mem_ack`.
- R4: During a read-miss fill, `cpu_rdy` and `cpu_rdata` are given on the edge that accepts the beat whose offset equals the requested offset, before the remaining beats of the block are fetched.
- R5: A write to a cached address updates only the cached word and marks the line modified; no memory write takes place, and a later read of that address returns the written value.
- R6: When a miss maps to a line that is valid and modified, all `WORDS` words of the old block are written to memory at the old block's addresses, in offset order, before the first read of the new block is issued.
- R7: When a miss maps to a line that is valid but not modified, or to a line that is not valid, no memory write occurs.
- R8: A write miss reads the whole block from memory, stores the written word in place of the fetched one, marks the line modified, and raises `cpu_rdy` on the edge that accepts the last fill beat.
- R9: `cpu_rdy` pulses exactly once for each request. A request presented while a copy-back or fill is running is held off and served only after the controller returns to idle.
- R10: The word address splits into offset bits [1:0], line index bits [5:2] and tag bits [9:6] (default parameters). Blocks with different line indices occupy separate lines, and a line is replaced only when a miss needs it for a block with a different tag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until `cpu_rdy` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Processor word address |
| cpu_wdata | input | DATA_W | Processor write data |
| cpu_rdy | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_rdy` |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 = memory write beat |
| mem_addr | output | ADDR_W | Memory word address of the beat |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | Memory beat accepted / read data valid |
| mem_rdata | input | DATA_W | Memory read data, valid with `mem_ack` |

## Verification
A wrong tag, valid flag or modified flag shows up at the memory port on the next access that maps to that line. The symptoms are a fetch where a hit was due, a hit where a fetch was due, or a copy-back that is missing or spurious. Corrupt cached data shows up on `cpu_rdata` at the next read of that word, or in `mem_wdata` at the copy-back. Errors in beat order or early return show up within the same miss: the number of memory beats completed at the moment `cpu_rdy` rises, and the address sequence of those beats, no longer match the requested offset.

// File: rtl/wbcache_pkg.sv
package wbcache_pkg;

  // controller phases
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WBACK = 2'd1,
    ST_FILL  = 2'd2
  } ctl_state_t;

endpackage

// File: rtl/wbc_tag_store.sv
module wbc_tag_store #(
  parameter int LINES = 16,
  parameter int TAG_W = 4,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic             rd_dirty,
  output logic [TAG_W-1:0] rd_tag,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic [TAG_W-1:0] upd_tag,
  input  logic             upd_dirty
);

  logic [LINES-1:0] valid_q, valid_d;
  logic [LINES-1:0] dirty_q, dirty_d;
  logic [TAG_W-1:0] tag_q [LINES];

  // next-state for the flag vectors
  always_comb begin
    valid_d = valid_q;
    dirty_d = dirty_q;
    if (upd_en) begin
      valid_d[upd_idx] = 1'b1;
      dirty_d[upd_idx] = upd_dirty;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      valid_q <= valid_d;
      dirty_q <= dirty_d;
    end
  end

  // tag storage: one enabled register per line, no reset needed
  for (genvar g = 0; g < LINES; g++) begin : g_tag
    logic line_we;
    assign line_we = upd_en && (upd_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (line_we) begin
        tag_q[g] <= upd_tag;
      end
    end
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_dirty = dirty_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];

  // a modified line is always a valid one
  assert_dirty_needs_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((dirty_q & ~valid_q) == '0));

endmodule

// File: rtl/wbc_data_store.sv
module wbc_data_store #(
  parameter int LINES  = 16,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(LINES),
  localparam int OFF_W = $clog2(WORDS),
  localparam int DEPTH = LINES * WORDS
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [OFF_W-1:0]  rd_off,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [DATA_W-1:0] wr_data
);

  logic [DATA_W-1:0] words_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      words_q[{wr_idx, wr_off}] <= wr_data;
    end
  end

  assign rd_data = words_q[{rd_idx, rd_off}];

endmodule

// File: rtl/wbc_ctrl.sv
module wbc_ctrl
  import wbcache_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LINES  = 16,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(LINES),
  localparam int OFF_W = $clog2(WORDS),
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  // processor side
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_rdy,
  output logic [DATA_W-1:0] cpu_rdata,
  // memory side
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  // tag store
  output logic [IDX_W-1:0]  tg_idx,
  input  logic              tg_valid,
  input  logic              tg_dirty,
  input  logic [TAG_W-1:0]  tg_tag,
  output logic              tg_upd_en,
  output logic [IDX_W-1:0]  tg_upd_idx,
  output logic [TAG_W-1:0]  tg_upd_tag,
  output logic              tg_upd_dirty,
  // data store
  output logic [IDX_W-1:0]  dt_rd_idx,
  output logic [OFF_W-1:0]  dt_rd_off,
  input  logic [DATA_W-1:0] dt_rd_data,
  output logic              dt_wr_en,
  output logic [IDX_W-1:0]  dt_wr_idx,
  output logic [OFF_W-1:0]  dt_wr_off,
  output logic [DATA_W-1:0] dt_wr_data
);

  localparam logic [OFF_W-1:0] LAST_BEAT = OFF_W'(WORDS - 1);

  // field split of the incoming address
  logic [OFF_W-1:0] in_off;
  logic [IDX_W-1:0] in_idx;
  logic [TAG_W-1:0] in_tag;
  assign in_off = cpu_addr[OFF_W-1:0];
  assign in_idx = cpu_addr[OFF_W +: IDX_W];
  assign in_tag = cpu_addr[ADDR_W-1 -: TAG_W];

  // registered state
  ctl_state_t        state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              we_q, we_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic [OFF_W-1:0]  beat_q, beat_d;
  logic              rdy_q, rdy_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;

  // fields of the request being served by a miss
  logic [OFF_W-1:0] pend_off;
  logic [IDX_W-1:0] pend_idx;
  logic [TAG_W-1:0] pend_tag;
  assign pend_off = addr_q[OFF_W-1:0];
  assign pend_idx = addr_q[OFF_W +: IDX_W];
  assign pend_tag = addr_q[ADDR_W-1 -: TAG_W];

  logic idle, lookup_hit, last_beat, beat_is_target;
  assign idle           = (state_q == ST_IDLE);
  assign lookup_hit     = tg_valid && (tg_tag == in_tag);
  assign last_beat      = (beat_q == LAST_BEAT);
  assign beat_is_target = (beat_q == pend_off);

  // store read addressing: the request in idle, the pending line otherwise
  always_comb begin
    if (idle) begin
      tg_idx    = in_idx;
      dt_rd_idx = in_idx;
      dt_rd_off = in_off;
    end else begin
      tg_idx    = pend_idx;
      dt_rd_idx = pend_idx;
      dt_rd_off = beat_q;
    end
  end

  // next-state and control
  always_comb begin
    state_d      = state_q;
    addr_d       = addr_q;
    we_d         = we_q;
    wdata_d      = wdata_q;
    beat_d       = beat_q;
    rdy_d        = 1'b0;
    rdata_d      = rdata_q;
    mem_req      = 1'b0;
    mem_we       = 1'b0;
    mem_addr     = '0;
    mem_wdata    = '0;
    tg_upd_en    = 1'b0;
    tg_upd_idx   = pend_idx;
    tg_upd_tag   = pend_tag;
    tg_upd_dirty = 1'b0;
    dt_wr_en     = 1'b0;
    dt_wr_idx    = pend_idx;
    dt_wr_off    = beat_q;
    dt_wr_data   = mem_rdata;

    unique case (state_q)
      ST_IDLE: begin
        if (cpu_req) begin
          if (lookup_hit) begin
            rdy_d   = 1'b1;
            rdata_d = dt_rd_data;
            if (cpu_we) begin
              dt_wr_en     = 1'b1;
              dt_wr_idx    = in_idx;
              dt_wr_off    = in_off;
              dt_wr_data   = cpu_wdata;
              tg_upd_en    = 1'b1;
              tg_upd_idx   = in_idx;
              tg_upd_tag   = in_tag;
              tg_upd_dirty = 1'b1;
              rdata_d      = cpu_wdata;
            end
          end else begin
            addr_d  = cpu_addr;
            we_d    = cpu_we;
            wdata_d = cpu_wdata;
            beat_d  = '0;
            state_d = (tg_valid && tg_dirty) ? ST_WBACK : ST_FILL;
          end
        end
      end

      ST_WBACK: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = {tg_tag, pend_idx, beat_q};
        mem_wdata = dt_rd_data;
        if (mem_ack) begin
          beat_d = beat_q + OFF_W'(1);
          if (last_beat) begin
            state_d = ST_FILL;
          end
        end
      end

      ST_FILL: begin
        mem_req  = 1'b1;
        mem_addr = {pend_tag, pend_idx, beat_q};
        if (mem_ack) begin
          dt_wr_en   = 1'b1;
          dt_wr_data = (we_q && beat_is_target) ? wdata_q : mem_rdata;
          beat_d     = beat_q + OFF_W'(1);
          // early return of the requested word
          if (!we_q && beat_is_target) begin
            rdy_d   = 1'b1;
            rdata_d = mem_rdata;
          end
          if (last_beat) begin
            tg_upd_en    = 1'b1;
            tg_upd_dirty = we_q;
            state_d      = ST_IDLE;
            if (we_q) begin
              rdy_d   = 1'b1;
              rdata_d = wdata_q;
            end
          end
        end
      end

      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
      beat_q  <= '0;
      rdy_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      we_q    <= we_d;
      wdata_q <= wdata_d;
      beat_q  <= beat_d;
      rdy_q   <= rdy_d;
      rdata_q <= rdata_d;
    end
  end

  assign cpu_rdy   = rdy_q;
  assign cpu_rdata = rdata_q;

  // memory beat held stable until accepted
  assert_beat_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // refill reads start only after the last copy-back beat was accepted
  assert_wback_before_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && $past(mem_req) && $past(mem_we))
      |-> ($past(mem_ack) && ($past(beat_q) == LAST_BEAT)));

  // an early return during a fill is not followed by a second pulse
  assert_single_rdy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && cpu_rdy) |=> !cpu_rdy);

  // no completion while the victim is being copied out
  assert_no_rdy_in_wback_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WBACK) |-> !cpu_rdy);

endmodule

// File: rtl/wbcache_lt.sv
module wbcache_lt #(
  parameter int ADDR_W = 10,
  parameter int LINES  = 16,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_rdy,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);

  localparam int IDX_W = $clog2(LINES);
  localparam int OFF_W = $clog2(WORDS);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

  logic [IDX_W-1:0]  tg_idx;
  logic              tg_valid, tg_dirty;
  logic [TAG_W-1:0]  tg_tag;
  logic              tg_upd_en, tg_upd_dirty;
  logic [IDX_W-1:0]  tg_upd_idx;
  logic [TAG_W-1:0]  tg_upd_tag;
  logic [IDX_W-1:0]  dt_rd_idx, dt_wr_idx;
  logic [OFF_W-1:0]  dt_rd_off, dt_wr_off;
  logic [DATA_W-1:0] dt_rd_data, dt_wr_data;
  logic              dt_wr_en;

  wbc_ctrl #(
    .ADDR_W(ADDR_W), .LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W)
  ) ctrl_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_req      (cpu_req),
    .cpu_we       (cpu_we),
    .cpu_addr     (cpu_addr),
    .cpu_wdata    (cpu_wdata),
    .cpu_rdy      (cpu_rdy),
    .cpu_rdata    (cpu_rdata),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .mem_ack      (mem_ack),
    .mem_rdata    (mem_rdata),
    .tg_idx       (tg_idx),
    .tg_valid     (tg_valid),
    .tg_dirty     (tg_dirty),
    .tg_tag       (tg_tag),
    .tg_upd_en    (tg_upd_en),
    .tg_upd_idx   (tg_upd_idx),
    .tg_upd_tag   (tg_upd_tag),
    .tg_upd_dirty (tg_upd_dirty),
    .dt_rd_idx    (dt_rd_idx),
    .dt_rd_off    (dt_rd_off),
    .dt_rd_data   (dt_rd_data),
    .dt_wr_en     (dt_wr_en),
    .dt_wr_idx    (dt_wr_idx),
    .dt_wr_off    (dt_wr_off),
    .dt_wr_data   (dt_wr_data)
  );

  wbc_tag_store #(
    .LINES(LINES), .TAG_W(TAG_W)
  ) tags_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_idx    (tg_idx),
    .rd_valid  (tg_valid),
    .rd_dirty  (tg_dirty),
    .rd_tag    (tg_tag),
    .upd_en    (tg_upd_en),
    .upd_idx   (tg_upd_idx),
    .upd_tag   (tg_upd_tag),
    .upd_dirty (tg_upd_dirty)
  );

  wbc_data_store #(
    .LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W)
  ) data_i (
    .clk     (clk),
    .rd_idx  (dt_rd_idx),
    .rd_off  (dt_rd_off),
    .rd_data (dt_rd_data),
    .wr_en   (dt_wr_en),
    .wr_idx  (dt_wr_idx),
    .wr_off  (dt_wr_off),
    .wr_data (dt_wr_data)
  );

endmodule

// File: tb/wbcache_lt_tb_top.sv
`timescale 1ns/1ps
module wbcache_lt_tb_top;

  localparam int ADDR_W = 10;
  localparam int DATA_W = 32;
  localparam int MSIZE  = 1 << ADDR_W;
  localparam int LAT    = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cpu_req = 1'b0;
  logic              cpu_we = 1'b0;
  logic [ADDR_W-1:0] cpu_addr = '0;
  logic [DATA_W-1:0] cpu_wdata = '0;
  logic              cpu_rdy;
  logic [DATA_W-1:0] cpu_rdata;
  logic              mem_req, mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata;
  logic              mem_ack = 1'b0;
  logic [DATA_W-1:0] mem_rdata = '0;

  always #4 clk = ~clk;

  wbcache_lt dut_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdy(cpu_rdy), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  // ---------------- memory model with beat log ----------------
  logic [DATA_W-1:0] mem_arr [MSIZE];
  logic              log_we   [64];
  logic [ADDR_W-1:0] log_addr [64];
  logic [DATA_W-1:0] log_data [64];
  int n_ops = 0;
  int lat_cnt = LAT;
  int rdy_total = 0;

  function automatic logic [DATA_W-1:0] seed(input int a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0000;
  endfunction

  initial begin
    for (int i = 0; i < MSIZE; i++) mem_arr[i] = seed(i);
  end

  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack <= 1'b0;
    end else if (mem_req) begin
      if (lat_cnt == 0) begin
        mem_ack <= 1'b1;
        lat_cnt <= LAT;
        log_we[n_ops % 64]   <= mem_we;
        log_addr[n_ops % 64] <= mem_addr;
        if (mem_we) begin
          mem_arr[mem_addr]    <= mem_wdata;
          log_data[n_ops % 64] <= mem_wdata;
        end else begin
          mem_rdata            <= mem_arr[mem_addr];
          log_data[n_ops % 64] <= mem_arr[mem_addr];
        end
        n_ops <= n_ops + 1;
      end else begin
        lat_cnt <= lat_cnt - 1;
      end
    end
    if (cpu_rdy) rdy_total <= rdy_total + 1;
  end

  // ---------------- checking helpers ----------------
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] mk(input int tag, input int idx, input int off);
    return ADDR_W'((tag << 6) | (idx << 2) | off);
  endfunction

  // one processor request; returns data, cycles to rdy and beats seen at rdy
  task automatic cpu_op(input bit we, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] wd,
                        output logic [DATA_W-1:0] rd, output int cyc, output int ops_at);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    cyc = 0; rd = '0; ops_at = 0;
    while (1) begin
      @(negedge clk);
      cyc++;
      if (cpu_rdy) begin
        rd = cpu_rdata; ops_at = n_ops;
        break;
      end
      if (cyc > 400) begin
        chk(1'b0, "R9", "request never completed", 32'(cyc), 32'd0);
        break;
      end
    end
    cpu_req = 1'b0; cpu_we = 1'b0;
  endtask

  task automatic wait_idle();
    int guard = 0;
    while (mem_req && guard < 400) begin
      @(negedge clk);
      guard++;
    end
    @(negedge clk);
  endtask

  logic [ADDR_W-1:0] A, B, C, D, E, F;
  logic [DATA_W-1:0] XV, YV;

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk(cpu_rdy == 1'b0, "R1", "rdy after reset", 32'(cpu_rdy), 32'd0);
    chk(mem_req == 1'b0, "R1", "mem_req after reset", 32'(mem_req), 32'd0);
  endtask

  task automatic t_cold_read();
    logic [DATA_W-1:0] rd; int cyc, at; int base;
    base = n_ops;
    cpu_op(1'b0, A, '0, rd, cyc, at);
    chk(rd == seed(int'(A)), "R4", "early read data", rd, seed(int'(A)));
    chk(at - base == 3, "R4", "beats done at rdy (offset 2)", 32'(at - base), 32'd3);
    wait_idle();
    chk(n_ops - base == 4, "R1", "cold miss beats", 32'(n_ops - base), 32'd4);
    for (int k = 0; k < 4; k++) begin
      chk(!log_we[(base + k) % 64] && log_addr[(base + k) % 64] == mk(1, 2, k), "R3",
          "fill beat address", 32'(log_addr[(base + k) % 64]), 32'(mk(1, 2, k)));
    end
  endtask

  task automatic t_read_hit();
    logic [DATA_W-1:0] rd; int cyc, at; int base;
    base = n_ops;
    cpu_op(1'b0, A, '0, rd, cyc, at);
    chk(cyc == 1, "R2", "hit latency", 32'(cyc), 32'd1);
    chk(rd == seed(int'(A)), "R2", "hit data", rd, seed(int'(A)));
    cpu_op(1'b0, mk(1, 2, 0), '0, rd, cyc, at);
    chk(rd == seed(int'(mk(1, 2, 0))), "R2", "hit data other word", rd, seed(int'(mk(1, 2, 0))));
    wait_idle();
    chk(n_ops == base, "R2", "memory beats on hits", 32'(n_ops - base), 32'd0);
  endtask

  task automatic t_write_hit();
    logic [DATA_W-1:0] rd; int cyc, at; int base;
    base = n_ops;
    cpu_op(1'b1, A, XV, rd, cyc, at);
    chk(cyc == 1, "R5", "write hit latency", 32'(cyc), 32'd1);
    cpu_op(1'b0, A, '0, rd, cyc, at);
    chk(rd == XV, "R5", "read after write hit", rd, XV);
    wait_idle();
    chk(n_ops == base, "R5", "memory beats on write hit", 32'(n_ops - base), 32'd0);
    chk(mem_arr[A] == seed(int'(A)), "R5", "memory untouched", mem_arr[A], seed(int'(A)));
  endtask

  task automatic t_dirty_evict();
    logic [DATA_W-1:0] rd; int cyc, at; int base;
    base = n_ops;
    cpu_op(1'b0, B, '0, rd, cyc, at);
    chk(rd == seed(int'(B)), "R6", "data after copy-back", rd, seed(int'(B)));
    chk(at - base == 6, "R6", "beats at rdy (4 wb + offset 1)", 32'(at - base), 32'd6);
    wait_idle();
    chk(n_ops - base == 8, "R6", "total beats", 32'(n_ops - base), 32'd8);
    for (int k = 0; k < 4; k++) begin
      chk(log_we[(base + k) % 64] && log_addr[(base + k) % 64] == mk(1, 2, k), "R6",
          "copy-back beat", 32'(log_addr[(base + k) % 64]), 32'(mk(1, 2, k)));
      chk(!log_we[(base + 4 + k) % 64] && log_addr[(base + 4 + k) % 64] == mk(5, 2, k), "R6",
          "refill beat after copy-back", 32'(log_addr[(base + 4 + k) % 64]), 32'(mk(5, 2, k)));
    end
    chk(mem_arr[A] == XV, "R6", "modified word written back", mem_arr[A], XV);
  endtask

  task automatic t_clean_evict();
    logic [DATA_W-1:0] rd; int cyc, at; int base;
    base = n_ops;
    cpu_op(1'b0, A, '0, rd, cyc, at);
    wait_idle();
    chk(rd == XV, "R6", "reload returns written value", rd, XV);
    chk(n_ops - base == 4, "R7", "clean victim beats", 32'(n_ops - base), 32'd4);
    for (int k = 0; k < 4; k++)
      chk(!log_we[(base + k) % 64], "R7", "no write for clean victim", 32'(log_we[(base + k) % 64]), 32'd0);
    // a different index must not disturb line 2
    cpu_op(1'b0, C, '0, rd, cyc, at);
    wait_idle();
    chk(rd == seed(int'(C)), "R10", "other index data", rd, seed(int'(C)));
    base = n_ops;
    cpu_op(1'b0, A, '0, rd, cyc, at);
    chk(cyc == 1 && n_ops == base, "R10", "line 2 still hits", 32'(cyc), 32'd1);
  endtask

  task automatic t_write_miss();
    logic [DATA_W-1:0] rd; int cyc, at; int base;
    base = n_ops;
    cpu_op(1'b1, D, YV, rd, cyc, at);
    chk(at - base == 4, "R8", "write miss rdy after last beat", 32'(at - base), 32'd4);
    wait_idle();
    chk(n_ops - base == 4, "R8", "write miss beats", 32'(n_ops - base), 32'd4);
    chk(mem_arr[D] == seed(int'(D)), "R8", "memory not written", mem_arr[D], seed(int'(D)));
    cpu_op(1'b0, D, '0, rd, cyc, at);
    chk(rd == YV && cyc == 1, "R8", "merged word hits", rd, YV);
    cpu_op(1'b0, mk(2, 9, 0), '0, rd, cyc, at);
    chk(rd == seed(int'(mk(2, 9, 0))), "R8", "fetched neighbour word", rd, seed(int'(mk(2, 9, 0))));
    base = n_ops;
    cpu_op(1'b0, E, '0, rd, cyc, at);
    wait_idle();
    chk(log_we[(base + 3) % 64] && log_data[(base + 3) % 64] == YV, "R8",
        "line was modified, merged word copied back", log_data[(base + 3) % 64], YV);
    chk(rd == seed(int'(E)), "R8", "read after evicting written line", rd, seed(int'(E)));
  endtask

  task automatic t_stall();
    logic [DATA_W-1:0] rd; int cyc, at; int base, r0;
    base = n_ops; r0 = rdy_total;
    cpu_op(1'b0, F, '0, rd, cyc, at);
    chk(at - base == 1, "R4", "offset 0 returned after first beat", 32'(at - base), 32'd1);
    cpu_op(1'b0, A, '0, rd, cyc, at);
    chk(at - base == 4, "R9", "request held until fill done", 32'(at - base), 32'd4);
    chk(rd == XV, "R9", "held request data", rd, XV);
    wait_idle();
    repeat (3) @(negedge clk);
    chk(rdy_total - r0 == 2, "R9", "rdy pulses for two requests", 32'(rdy_total - r0), 32'd2);
  endtask

  // ---------------- main sequence ----------------
  initial begin
    A = mk(1, 2, 2); B = mk(5, 2, 1); C = mk(3, 7, 0);
    D = mk(2, 9, 3); E = mk(6, 9, 0); F = mk(7, 4, 0);
    XV = 32'hC0DE_1234; YV = 32'hBEEF_0077;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cold_read();
    t_read_hit();
    t_write_hit();
    t_dirty_evict();
    t_clean_evict();
    t_write_miss();
    t_stall();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule